// File: doc/BRIEF.md
# Serial Management Interface Master

This block acts as the master on a two-wire PHY management bus. It generates the management clock (MDC) from the system clock and drives the bidirectional data line. It serialises Clause 22 read and write frames, starting one for each accepted command. A write frame shifts out the PHY address, the register address and 16 data bits. A read frame releases the line after the address fields, captures 16 bits from the PHY, and returns them with a one-cycle completion pulse.

A single 32-bit control word configures the block. Its fields are:

| Bits | Field | Access |
|------|-------|--------|
| 15:0 | clock divider | read/write |
| 16 | run enable | read/write |
| 17 | preamble suppression | read/write |
| 18 | line-fault detection enable | read/write |
| 19 | sticky fault flag | cleared by writing 1 |
| 20 | sequencer idle status | read-only |

When fault detection is on, the block compares the level it drives against the pin readback at each MDC rising edge. On a mismatch it sets the fault flag and abandons the frame. Clearing the enable bit never cuts a frame short: the frame in progress runs to its end before the block reports idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x001000FF: idle bit 20 set, divider 255, bits 16 to 19 clear. MDC is low and the line is released (mdioOe = 0).
- R2: While the divider value D is nonzero, MDC is a free-running clock whose period is exactly D+1 system clock cycles.
- R3: While the divider is 0, MDC stays low, cmdReady stays 0 and a presented command produces no frame and no done pulse.
- R4: A command is taken on a cycle where cmdValid and cmdReady are both 1. cmdReady is 1 only when the sequencer is idle, bit 16 is 1 and the divider is nonzero, so no command is taken while a frame is running or while the block is disabled.
- R5: A write frame drives these bits, MSB first: 32 ones, then 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and 16 data bits. A new bit is presented after each MDC falling edge, and the line is driven and stable at each MDC rising edge.
- R6: A read frame drives 32 ones, 01, opcode 10, the PHY address and the register address. It then releases the line for 18 bit times. The last 16 of these are sampled at MDC rising edges, MSB first, and the result appears on rdData together with done.
- R7: With bit 17 set, the 32 preamble ones are omitted and the frame starts directly with the 01 start field. With bit 17 clear, the preamble is sent.
- R8: done is a single-cycle pulse, given once for each frame that ends normally.
- R9: Clearing bit 16 during a frame lets that frame finish, with its done pulse. Idle (bit 20) then reads 1 and no further command is taken.
- R10: With bit 18 set, a driven bit whose readback differs at an MDC rising edge causes four things: the fault flag (bit 19) is set, the frame is abandoned without a done pulse, the line is released and the sequencer returns to idle.
- R11: The fault flag stays set until a control write with bit 19 equal to 1 clears it. A control write with bit 19 equal to 0 leaves it unchanged.
- R12: No fault is raised for bit times in which the line is released, nor at any time while bit 18 is clear.
- R13: Bit 20 reads 1 exactly while the sequencer is idle, and the line is never driven while it reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write value |
| cfgRdData | output | 32 | Control word read value |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command can be taken this cycle |
| cmdRead | input | 1 | 1 = read frame, 0 = write frame |
| cmdPhy | input | 5 | PHY address |
| cmdReg | input | 5 | Register address |
| cmdWrData | input | 16 | Data for a write frame |
| rdData | output | 16 | Data captured by the last read frame |
| done | output | 1 | Frame completed normally (one cycle) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line pin readback |

## Verification
A wrong bit counter or a wrong shift register shows up as a corrupted serial frame on the data line: a wrong length, a misplaced turnaround or swapped fields. The scoreboard catches it when the done pulse arrives, within one frame time. A sequencer stuck out of idle shows up at once as a clear idle bit and a low cmdReady, and any missing done pulse is caught by the bounded wait that follows each command. A divider counter that misbehaves changes the measured spacing between MDC rising edges within two MDC periods. A fault path that fires while the line is released, or one that fails to clear, shows up in the control word at the next read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CFG_W     = 32;
  localparam int CFG_EN    = 16;
  localparam int CFG_NOPRE = 17;
  localparam int CFG_FEN   = 18;
  localparam int CFG_FAULT = 19;
  localparam int CFG_IDLE  = 20;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARM, SEQ_RUN} seqState_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
    logic finish;
    logic abort;
  } seqStrobe_t;
endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divider,
  input  seqStrobe_t        stb,
  input  logic              ldRead,
  input  logic              ldNoPre,
  input  logic [ADDR_W-1:0] ldPhy,
  input  logic [ADDR_W-1:0] ldReg,
  input  logic [DATA_W-1:0] ldData,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              fallEv,
  output logic              riseEv,
  output logic              bitsZero,
  output logic              inData,
  output logic              mismatch,
  output logic [DATA_W-1:0] rdData
);
  localparam int BODY_LEN  = 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int FRAME_MAX = PRE_LEN + BODY_LEN;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int RLS_LEN   = 2 + DATA_W;
  localparam logic [CNT_W-1:0] RLS_C   = CNT_W'(RLS_LEN);
  localparam logic [CNT_W-1:0] DATA_C  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(FRAME_MAX);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(BODY_LEN);

  // MDC generation
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   divPlusOne;
  logic [DIV_W-1:0] halfPoint;
  logic             divNz;

  assign divNz      = (divider != '0);
  assign divPlusOne = {1'b0, divider} + 1'b1;
  assign halfPoint  = divPlusOne[DIV_W:1];
  assign fallEv     = divNz && (divCnt >= divider);
  assign riseEv     = divNz && !fallEv && (divCnt == halfPoint - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !divNz) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (fallEv) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (riseEv) mdc <= 1'b1;
    end
  end

  // Frame assembly
  logic [BODY_LEN-1:0]  body;
  logic [FRAME_MAX-1:0] frameLoad;

  assign body = {2'b01, (ldRead ? 2'b10 : 2'b01), ldPhy, ldReg,
                 (ldRead ? 2'b00 : 2'b10),
                 (ldRead ? {DATA_W{1'b0}} : ldData)};

  generate
    if (PRE_LEN > 0) begin : g_pre
      assign frameLoad = ldNoPre ? {body, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, body};
    end else begin : g_nopre
      assign frameLoad = body;
    end
  endgenerate

  // Shifter and line drive
  logic [FRAME_MAX-1:0] sr;
  logic [CNT_W-1:0]     bitsLeft;
  logic [CNT_W-1:0]     nextLeft;
  logic                 isRead;
  logic [DATA_W-1:0]    rdShift;

  assign nextLeft = bitsLeft - 1'b1;
  assign bitsZero = (bitsLeft == '0);
  assign inData   = isRead && (bitsLeft < DATA_C);
  assign mismatch = mdioOe && (mdioIn != mdioOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr       <= '0;
      bitsLeft <= '0;
      isRead   <= 1'b0;
      mdioOut  <= 1'b0;
      mdioOe   <= 1'b0;
      rdShift  <= '0;
      rdData   <= '0;
    end else begin
      if (stb.load) begin
        sr       <= frameLoad;
        bitsLeft <= ldNoPre ? SHORT_C : FULL_C;
        isRead   <= ldRead;
      end
      if (stb.advance) begin
        mdioOut  <= sr[FRAME_MAX-1];
        mdioOe   <= !(isRead && (nextLeft < RLS_C));
        sr       <= {sr[FRAME_MAX-2:0], 1'b0};
        bitsLeft <= nextLeft;
      end
      if (stb.capture) rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (stb.finish) begin
        mdioOut <= 1'b0;
        mdioOe  <= 1'b0;
        rdData  <= rdShift;
      end
      if (stb.abort) begin
        mdioOut <= 1'b0;
        mdioOe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic             fallEv,
  input  logic             riseEv,
  input  logic             bitsZero,
  input  logic             inData,
  input  logic             mismatch,
  output logic [DIV_W-1:0] divider,
  output logic             noPre,
  output seqStrobe_t       stb,
  output logic             done
);
  logic      runEn;
  logic      faultEn;
  logic      faultFlag;
  logic      setFault;
  logic      finishing;
  seqState_t state;
  seqState_t stateNext;

  assign cmdReady = (state == SEQ_IDLE) && runEn && (divider != '0);

  always_comb begin
    stb       = '0;
    stateNext = state;
    setFault  = 1'b0;
    finishing = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (cmdValid && cmdReady) begin
          stb.load  = 1'b1;
          stateNext = SEQ_ARM;
        end
      end
      SEQ_ARM: begin
        if (fallEv) begin
          stb.advance = 1'b1;
          stateNext   = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (faultEn && riseEv && mismatch) begin
          stb.abort = 1'b1;
          setFault  = 1'b1;
          stateNext = SEQ_IDLE;
        end else begin
          if (riseEv && inData) stb.capture = 1'b1;
          if (fallEv) begin
            if (bitsZero) begin
              stb.finish = 1'b1;
              finishing  = 1'b1;
              stateNext  = SEQ_IDLE;
            end else begin
              stb.advance = 1'b1;
            end
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      done      <= 1'b0;
      divider   <= DIV_W'(DIV_RESET);
      runEn     <= 1'b0;
      noPre     <= 1'b0;
      faultEn   <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finishing;
      if (cfgWe) begin
        divider <= cfgWrData[DIV_W-1:0];
        runEn   <= cfgWrData[CFG_EN];
        noPre   <= cfgWrData[CFG_NOPRE];
        faultEn <= cfgWrData[CFG_FEN];
      end
      if (setFault) faultFlag <= 1'b1;
      else if (cfgWe && cfgWrData[CFG_FAULT]) faultFlag <= 1'b0;
    end
  end

  always_comb begin
    cfgRdData              = '0;
    cfgRdData[DIV_W-1:0]   = divider;
    cfgRdData[CFG_EN]      = runEn;
    cfgRdData[CFG_NOPRE]   = noPre;
    cfgRdData[CFG_FEN]     = faultEn;
    cfgRdData[CFG_FAULT]   = faultFlag;
    cfgRdData[CFG_IDLE]    = (state == SEQ_IDLE);
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 255,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdPhy,
  input  logic [ADDR_W-1:0] cmdReg,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  seqStrobe_t       stb;
  logic [DIV_W-1:0] divider;
  logic             noPre;
  logic             fallEv;
  logic             riseEv;
  logic             bitsZero;
  logic             inData;
  logic             mismatch;

  mdio_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .fallEv(fallEv), .riseEv(riseEv), .bitsZero(bitsZero),
    .inData(inData), .mismatch(mismatch),
    .divider(divider), .noPre(noPre), .stb(stb), .done(done)
  );

  mdio_dp #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .divider(divider), .stb(stb),
    .ldRead(cmdRead), .ldNoPre(noPre), .ldPhy(cmdPhy), .ldReg(cmdReg),
    .ldData(cmdWrData), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .fallEv(fallEv), .riseEv(riseEv), .bitsZero(bitsZero),
    .inData(inData), .mismatch(mismatch), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cfgWe,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic        done,
  input logic        mdc,
  input logic        mdioOe
);
  // R13: idle means the line is released
  a_r13_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[CFG_IDLE] |-> !mdioOe);

  // R3: zero divider stops the clock
  a_r3_div0_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[15:0] == 16'd0) |=> !mdc);

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a fault returns the sequencer to idle
  a_r10_fault_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgRdData[CFG_FAULT]) |-> cfgRdData[CFG_IDLE]);

  // R11: fault flag is sticky until written with 1
  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[CFG_FAULT] && !(cfgWe && cfgWrData[CFG_FAULT])) |=> cfgRdData[CFG_FAULT]);

  // R4: an accepted command leaves idle
  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cfgRdData[CFG_IDLE]);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .done(done), .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdRead = 1'b0;
  logic [4:0]  cmdPhy = '0;
  logic [4:0]  cmdReg = '0;
  logic [15:0] cmdWrData = '0;
  logic [15:0] rdData;
  logic        done;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn;

  logic        phyBit = 1'b1;
  logic        injectFault = 1'b0;
  logic [15:0] phyWord = '0;

  assign mdioIn = mdioOe ? (injectFault ? ~mdioOut : mdioOut) : phyBit;

  always #2.5 clk = ~clk;

  mdio_mgmt_master dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRead(cmdRead), .cmdPhy(cmdPhy), .cmdReg(cmdReg),
    .cmdWrData(cmdWrData), .rdData(rdData), .done(done), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  typedef struct {
    int          cnt;
    logic [63:0] bits;
    logic        isRd;
    logic [15:0] rd;
  } exp_t;

  exp_t expQ[$];
  int   total = 0;
  int   fails = 0;
  int   doneCount = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  function automatic exp_t buildExp(input bit rd, input bit noPre, input logic [4:0] phy,
                                    input logic [4:0] rg, input logic [15:0] data);
    exp_t e;
    logic [15:0] hdr;
    e.cnt = 0; e.bits = '0; e.isRd = rd; e.rd = phyWord;
    if (!noPre) for (int i = 0; i < 32; i++) begin e.bits = {e.bits[62:0], 1'b1}; e.cnt++; end
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10};
    for (int i = 15; i >= (rd ? 2 : 0); i--) begin e.bits = {e.bits[62:0], hdr[i]}; e.cnt++; end
    if (!rd) for (int i = 15; i >= 0; i--) begin e.bits = {e.bits[62:0], data[i]}; e.cnt++; end
    return e;
  endfunction

  // Monitor: records driven bits at MDC rising edges, scores them at done
  logic [63:0] logBits = '0;
  int          logCnt = 0;
  logic        prevMdc = 1'b0;
  always @(negedge clk) begin
    if (mdc && !prevMdc && mdioOe) begin
      logBits = {logBits[62:0], mdioOut};
      logCnt++;
    end
    if (done) begin
      doneCount++;
      if (expQ.size() == 0) chk(0, "R8", "unexpected done", 64'd1, 64'd0);
      else begin
        exp_t e;
        logic [63:0] m;
        e = expQ.pop_front();
        m = (e.cnt >= 64) ? '1 : ((64'd1 << e.cnt) - 64'd1);
        chk(logCnt == e.cnt, e.isRd ? "R6" : "R5", "driven bit count", 64'(logCnt), 64'(e.cnt));
        chk((logBits & m) == (e.bits & m), e.isRd ? "R6" : "R5", "frame bits", logBits & m, e.bits & m);
        if (e.isRd) chk(rdData == e.rd, "R6", "read data", 64'(rdData), 64'(e.rd));
      end
      logBits = '0; logCnt = 0;
    end else if (cfgRdData[20]) begin
      logBits = '0; logCnt = 0;
    end
    prevMdc = mdc;
  end

  // PHY model: answers released bit times
  logic prevMdcP = 1'b0;
  int   relCnt = 0;
  always @(negedge clk) begin
    if (!mdc && prevMdcP) begin
      if (!mdioOe && !cfgRdData[20]) begin
        relCnt++;
        if (relCnt >= 3 && relCnt <= 18) phyBit = phyWord[18 - relCnt];
        else phyBit = 1'b0;
      end else begin
        relCnt = 0;
        phyBit = 1'b1;
      end
    end
    prevMdcP = mdc;
  end

  task automatic cfgWrite(input logic [15:0] div, input bit en, input bit noPre,
                          input bit fen, input bit clrFault);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWrData = '0;
    cfgWrData[15:0] = div;
    cfgWrData[16] = en; cfgWrData[17] = noPre; cfgWrData[18] = fen; cfgWrData[19] = clrFault;
    @(negedge clk);
    cfgWe = 1'b0;
    cfgWrData = '0;
  endtask

  task automatic issueCmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] data, input bit expectFrame);
    @(negedge clk);
    chk(cmdReady == 1'b1, "R4", "ready before command", 64'(cmdReady), 64'd1);
    if (expectFrame) expQ.push_back(buildExp(rd, cfgRdData[17], phy, rg, data));
    cmdValid = 1'b1; cmdRead = rd; cmdPhy = phy; cmdReg = rg; cmdWrData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int start = doneCount;
    int n = 0;
    while (doneCount == start && n < 4000) begin @(negedge clk); n++; end
    chk(doneCount != start, req, "done arrives", 64'(doneCount - start), 64'd1);
  endtask

  task automatic measurePeriod(input int div);
    int n = 0;
    while (!(mdc && !prevMdc)) @(negedge clk);
    @(negedge clk); n = 1;
    while (!(mdc && !prevMdc) && n < 1000) begin @(negedge clk); n++; end
    chk(n == div + 1, "R2", "MDC period", 64'(n), 64'(div + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run timed out", 64'd0, 64'd1);
    endRun();
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfgRdData == 32'h001000FF, "R1", "reset control word", 64'(cfgRdData), 64'h001000FF);
    chk(!mdc && !mdioOe, "R1", "reset pins", {62'd0, mdc, mdioOe}, 64'd0);
    // R4 disabled: not ready
    chk(cmdReady == 1'b0, "R4", "ready while disabled", 64'(cmdReady), 64'd0);

    // R2 periods
    cfgWrite(16'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    measurePeriod(5);
    cfgWrite(16'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    measurePeriod(2);

    // R5 write with preamble
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    issueCmd(1'b0, 5'h13, 5'h0A, 16'hA5C3, 1'b1);
    @(negedge clk);
    chk(cmdReady == 1'b0 && cfgRdData[20] == 1'b0, "R4", "busy blocks commands",
        {62'd0, cmdReady, cfgRdData[20]}, 64'd0);
    waitDone("R5");
    @(negedge clk);
    chk(cfgRdData[20] == 1'b1, "R13", "idle after frame", 64'(cfgRdData[20]), 64'd1);

    // R6 read with preamble
    phyWord = 16'h3C96;
    issueCmd(1'b1, 5'h01, 5'h1F, 16'hFFFF, 1'b1);
    waitDone("R6");
    phyWord = 16'hE001;
    issueCmd(1'b1, 5'h1E, 5'h02, 16'h0000, 1'b1);
    waitDone("R6");

    // R7 preamble suppressed, write and read
    cfgWrite(16'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    issueCmd(1'b0, 5'h05, 5'h11, 16'h0F0F, 1'b1);
    waitDone("R7");
    phyWord = 16'h8421;
    issueCmd(1'b1, 5'h0C, 5'h07, 16'h0000, 1'b1);
    waitDone("R7");

    // R3 zero divider
    cfgWrite(16'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    d0 = doneCount;
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = 1'b0;
    begin
      bit sawMdc = 0; bit sawReady = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (mdc) sawMdc = 1;
        if (cmdReady) sawReady = 1;
      end
      cmdValid = 1'b0;
      chk(!sawMdc, "R3", "MDC stopped", 64'(sawMdc), 64'd0);
      chk(!sawReady, "R3", "no ready", 64'(sawReady), 64'd0);
      chk(doneCount == d0 && cfgRdData[20], "R3", "no frame started",
          64'(doneCount - d0), 64'd0);
    end

    // R9 graceful disable
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    issueCmd(1'b0, 5'h0A, 5'h15, 16'h1234, 1'b1);
    repeat (40) @(negedge clk);
    cfgWrite(16'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(cfgRdData[20] == 1'b0, "R9", "still busy after disable", 64'(cfgRdData[20]), 64'd0);
    waitDone("R9");
    @(negedge clk);
    chk(cfgRdData[20] == 1'b1 && cmdReady == 1'b0, "R9", "idle and not ready",
        {62'd0, cfgRdData[20], cmdReady}, 64'h2);

    // R10 fault abort
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    injectFault = 1'b1;
    d0 = doneCount;
    issueCmd(1'b0, 5'h03, 5'h04, 16'hBEEF, 1'b0);
    repeat (40) @(negedge clk);
    chk(cfgRdData[19] == 1'b1, "R10", "fault flag set", 64'(cfgRdData[19]), 64'd1);
    chk(cfgRdData[20] == 1'b1 && !mdioOe, "R10", "idle and released",
        {62'd0, cfgRdData[20], mdioOe}, 64'h2);
    repeat (300) @(negedge clk);
    chk(doneCount == d0, "R10", "no done after fault", 64'(doneCount - d0), 64'd0);
    injectFault = 1'b0;

    // R11 write 0 keeps, write 1 clears
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(cfgRdData[19] == 1'b1, "R11", "write 0 keeps fault", 64'(cfgRdData[19]), 64'd1);
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(cfgRdData[19] == 1'b0, "R11", "write 1 clears fault", 64'(cfgRdData[19]), 64'd0);

    // R12 released bits never fault (PHY drives opposite levels)
    phyWord = 16'h5A5A;
    issueCmd(1'b1, 5'h07, 5'h09, 16'h0000, 1'b1);
    waitDone("R12");
    chk(cfgRdData[19] == 1'b0, "R12", "no fault on read", 64'(cfgRdData[19]), 64'd0);

    // R12 detection disabled ignores mismatch
    cfgWrite(16'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    injectFault = 1'b1;
    issueCmd(1'b0, 5'h1F, 5'h00, 16'h8001, 1'b1);
    waitDone("R12");
    injectFault = 1'b0;
    chk(cfgRdData[19] == 1'b0, "R12", "no fault when disabled", 64'(cfgRdData[19]), 64'd0);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R8", "all frames completed", 64'(expQ.size()), 64'd0);
    endRun();
  end
endmodule